// File: doc/BRIEF.md
# Write-Once System Option Registers

This block holds the start-up configuration of a small microcontroller in two 8-bit registers. A one-bit select on a simple read/write port chooses between them. The first register, the core options, covers the watchdog enable and its short/long timeout choice, permission to enter stop mode, the debug-pin function select and the reset-pin function select. The second register, the routing options, covers the watchdog clock source and whether the analog comparator output feeds capture channel 0. The decoded fields leave the block as single-bit control outputs for the watchdog, the pin multiplexers and the timer.

Most fields are write-once. Each register keeps its own lock flag, which the first write to that register sets. While the lock is set, writes leave the write-once bits of that register alone. The debug-pin select and the comparator routing bit stay writable at all times. Two reset inputs are kept apart. The power-on reset restores every field. The general reset restores everything except the reset-pin enable: once that bit is set, only power-on reset clears it.

The block also watches a STOP-attempt strobe from the core. If stop mode has not been enabled, it raises a registered, one-cycle illegal-opcode reset request.

Top module: `sysopt_regs`

## Requirements
- R1: On either reset, the core register resets to watchdog enable (bit 7) = 1, timeout select (bit 6) = 0, stop enable (bit 5) = 0 and debug-pin enable (bit 1) = 1. The routing register resets to all zeros.
- R2: The reset-pin enable (core register, bit 0) is 0 after power-on reset. The general reset alone leaves it unchanged. A write can set it but never clear it.
- R3: After each reset, the first write to the core register loads bits 7, 6 and 5 and may set bit 0. Later writes leave these bits unchanged until the next reset.
- R4: Every write to the core register loads bit 1 (debug-pin enable), whether or not the register is locked.
- R5: The routing register's bit 7 (watchdog clock select, 1 = bus clock) is loaded only by the first write after reset. Its bit 0 (comparator-to-capture routing) is loaded by every write to that register.
- R6: Unimplemented bits read as 0 and ignore writes. These are bits 4..2 of the core register and bits 6..1 of the routing register.
- R7: Read data is combinational. Select 0 returns the core register and select 1 returns the routing register. A write becomes visible on the read port after the clock edge that takes it.
- R8: When the STOP-attempt strobe is high in a non-reset cycle while stop enable is 0, the illegal-stop request is high for exactly the next cycle. No request follows when stop enable is 1 or when either reset is active.
- R9: Each control output equals its register bit. The reset-pin pull-up output equals the reset-pin enable.
- R10: The two lock flags are independent. Writing one register does not lock the other.
- R11: A reset in the same cycle as a write takes priority, and that write has no effect. This includes the lock flag, which stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | General (non-power-on) reset, synchronous, active high |
| bus_sel | input | 1 | Register select: 0 core, 1 routing |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| stop_try | input | 1 | Core attempted STOP this cycle |
| illegal_stop_req | output | 1 | Illegal-opcode reset request pulse |
| wdog_en | output | 1 | Watchdog enabled |
| wdog_long | output | 1 | Long watchdog timeout selected |
| wdog_busclk | output | 1 | Watchdog clocked from bus clock (0 = internal 1 kHz) |
| stop_ok | output | 1 | Stop mode permitted |
| dbg_pin_en | output | 1 | Shared pin used as debug pin (0 = output-only GPIO) |
| rst_pin_en | output | 1 | Shared pin used as reset input |
| rst_pin_pullup | output | 1 | Pull-up enable for the reset pin |
| cmp_to_cap | output | 1 | Comparator output routed to capture channel 0 |

## Verification
The bench applies a general reset after the reset-pin enable has been set. A design that treats both resets alike would drop the reset pin back to port mode at that point. It also writes a register twice in a row with opposite data: a missing or shared lock would let the second write reach the watchdog, stop or clock-select fields, or would block the first write to the other register. It puts writes in the same cycle as a reset, where a wrong priority would leave a stale field or a set lock. It also pulses the STOP strobe with stop mode both disabled and enabled, and during reset, so that a request that is missing, too long or raised from a stale enable is caught.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 1;

    // bit positions in the core options register
    localparam int CORE_WDOG_EN   = 7;
    localparam int CORE_WDOG_LONG = 6;
    localparam int CORE_STOP_EN   = 5;
    localparam int CORE_DBG_EN    = 1;
    localparam int CORE_RPIN_EN   = 0;

    // bit positions in the routing options register
    localparam int ROUTE_BUSCLK = 7;
    localparam int ROUTE_CMP    = 0;

    localparam logic [ADDR_W-1:0] SEL_CORE  = '0;
    localparam logic [ADDR_W-1:0] SEL_ROUTE = 1'b1;

    typedef struct packed {
        logic wdog_en;
        logic wdog_long;
        logic stop_en;
        logic dbg_en;
        logic rpin_en;
    } core_opts_t;

    typedef struct packed {
        logic busclk;
        logic cmp_route;
    } route_opts_t;

    localparam core_opts_t CORE_DEFAULT = '{
        wdog_en:   1'b1,
        wdog_long: 1'b0,
        stop_en:   1'b0,
        dbg_en:    1'b1,
        rpin_en:   1'b0
    };

    localparam route_opts_t ROUTE_DEFAULT = '{busclk: 1'b0, cmp_route: 1'b0};

    function automatic logic [REG_W-1:0] pack_core(core_opts_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[CORE_WDOG_EN]   = c.wdog_en;
        v[CORE_WDOG_LONG] = c.wdog_long;
        v[CORE_STOP_EN]   = c.stop_en;
        v[CORE_DBG_EN]    = c.dbg_en;
        v[CORE_RPIN_EN]   = c.rpin_en;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_route(route_opts_t r);
        logic [REG_W-1:0] v;
        v = '0;
        v[ROUTE_BUSCLK] = r.busclk;
        v[ROUTE_CMP]    = r.cmp_route;
        return v;
    endfunction

endpackage

// File: rtl/sysopt_core_reg.sv
module sysopt_core_reg
    import sysopt_pkg::*;
(
    input  logic             clk,
    input  logic             any_rst,
    input  logic             por_rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output core_opts_t       q,
    output logic             locked
);

    always_ff @(posedge clk) begin
        if (any_rst) begin
            q.wdog_en   <= CORE_DEFAULT.wdog_en;
            q.wdog_long <= CORE_DEFAULT.wdog_long;
            q.stop_en   <= CORE_DEFAULT.stop_en;
            q.dbg_en    <= CORE_DEFAULT.dbg_en;
            locked      <= 1'b0;
            // the reset-pin select survives every reset class except power-on
            if (por_rst) begin
                q.rpin_en <= CORE_DEFAULT.rpin_en;
            end
        end else if (wr) begin
            q.dbg_en <= wdata[CORE_DBG_EN];
            if (!locked) begin
                q.wdog_en   <= wdata[CORE_WDOG_EN];
                q.wdog_long <= wdata[CORE_WDOG_LONG];
                q.stop_en   <= wdata[CORE_STOP_EN];
                q.rpin_en   <= q.rpin_en | wdata[CORE_RPIN_EN];
                locked      <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysopt_route_reg.sv
module sysopt_route_reg
    import sysopt_pkg::*;
(
    input  logic             clk,
    input  logic             any_rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output route_opts_t      q,
    output logic             locked
);

    always_ff @(posedge clk) begin
        if (any_rst) begin
            q      <= ROUTE_DEFAULT;
            locked <= 1'b0;
        end else if (wr) begin
            q.cmp_route <= wdata[ROUTE_CMP];
            if (!locked) begin
                q.busclk <= wdata[ROUTE_BUSCLK];
                locked   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysopt_stop_guard.sv
module sysopt_stop_guard (
    input  logic clk,
    input  logic any_rst,
    input  logic stop_try,
    input  logic stop_en,
    output logic illegal_req
);

    always_ff @(posedge clk) begin
        if (any_rst) begin
            illegal_req <= 1'b0;
        end else begin
            illegal_req <= stop_try & ~stop_en;
        end
    end

endmodule

// File: rtl/sysopt_regs.sv
module sysopt_regs
    import sysopt_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst,
    input  logic             sys_rst,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             stop_try,
    output logic             illegal_stop_req,
    output logic             wdog_en,
    output logic             wdog_long,
    output logic             wdog_busclk,
    output logic             stop_ok,
    output logic             dbg_pin_en,
    output logic             rst_pin_en,
    output logic             rst_pin_pullup,
    output logic             cmp_to_cap
);

    logic        any_rst;
    logic        wr_core;
    logic        wr_route;
    core_opts_t  core_q;
    route_opts_t route_q;
    logic        core_locked;
    logic        route_locked;

    assign any_rst  = por_rst | sys_rst;
    assign wr_core  = bus_we & (bus_sel == SEL_CORE);
    assign wr_route = bus_we & (bus_sel == SEL_ROUTE);

    sysopt_core_reg u_core (
        .clk     (clk),
        .any_rst (any_rst),
        .por_rst (por_rst),
        .wr      (wr_core),
        .wdata   (bus_wdata),
        .q       (core_q),
        .locked  (core_locked)
    );

    sysopt_route_reg u_route (
        .clk     (clk),
        .any_rst (any_rst),
        .wr      (wr_route),
        .wdata   (bus_wdata),
        .q       (route_q),
        .locked  (route_locked)
    );

    sysopt_stop_guard u_guard (
        .clk         (clk),
        .any_rst     (any_rst),
        .stop_try    (stop_try),
        .stop_en     (core_q.stop_en),
        .illegal_req (illegal_stop_req)
    );

    always_comb begin
        if (bus_sel == SEL_ROUTE) begin
            bus_rdata = pack_route(route_q);
        end else begin
            bus_rdata = pack_core(core_q);
        end
    end

    assign wdog_en        = core_q.wdog_en;
    assign wdog_long      = core_q.wdog_long;
    assign stop_ok        = core_q.stop_en;
    assign dbg_pin_en     = core_q.dbg_en;
    assign rst_pin_en     = core_q.rpin_en;
    assign rst_pin_pullup = core_q.rpin_en;
    assign wdog_busclk    = route_q.busclk;
    assign cmp_to_cap     = route_q.cmp_route;

endmodule

// File: rtl/sysopt_checker.sv
module sysopt_checker (
    input logic       clk,
    input logic       por_rst,
    input logic       sys_rst,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       stop_try,
    input logic       illegal_stop_req,
    input logic       wdog_en,
    input logic       wdog_long,
    input logic       wdog_busclk,
    input logic       stop_ok,
    input logic       dbg_pin_en,
    input logic       rst_pin_en,
    input logic       rst_pin_pullup,
    input logic       cmp_to_cap
);

    logic any_rst;
    assign any_rst = por_rst | sys_rst;

    a_r1_reset_defaults: assert property (@(posedge clk)
        any_rst |=> (wdog_en && !wdog_long && !stop_ok && dbg_pin_en && !wdog_busclk && !cmp_to_cap));

    a_r2_por_clears_rpin: assert property (@(posedge clk)
        por_rst |=> !rst_pin_en);

    a_r2_sysrst_keeps_rpin: assert property (@(posedge clk) disable iff (por_rst)
        (sys_rst && rst_pin_en) |=> rst_pin_en);

    a_r3_core_second_write_ignored: assert property (@(posedge clk) disable iff (any_rst)
        (bus_we && !bus_sel && $past(bus_we && !bus_sel && !any_rst))
        |=> ($stable(wdog_en) && $stable(wdog_long) && $stable(stop_ok)));

    a_r5_route_second_write_ignored: assert property (@(posedge clk) disable iff (any_rst)
        (bus_we && bus_sel && $past(bus_we && bus_sel && !any_rst)) |=> $stable(wdog_busclk));

    a_r6_unimpl_zero: assert property (@(posedge clk)
        (bus_sel ? (bus_rdata[6:1] == 6'd0) : (bus_rdata[4:2] == 3'd0)));

    a_r8_illegal_raised: assert property (@(posedge clk) disable iff (any_rst)
        (stop_try && !stop_ok) |=> illegal_stop_req);

    a_r8_illegal_cause: assert property (@(posedge clk) disable iff (any_rst)
        illegal_stop_req |-> $past(stop_try && !stop_ok && !any_rst));

    a_r9_pullup_follows: assert property (@(posedge clk) disable iff (any_rst)
        $rose(rst_pin_en) |-> rst_pin_pullup);

endmodule

bind sysopt_regs sysopt_checker u_chk (.*);

// File: tb/sim_sysopt_regs.sv
module sim_sysopt_regs;

    logic       clk = 1'b0;
    logic       por_rst = 1'b1;
    logic       sys_rst = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       stop_try = 1'b0;
    logic [7:0] bus_rdata;
    logic       illegal_stop_req, wdog_en, wdog_long, wdog_busclk, stop_ok;
    logic       dbg_pin_en, rst_pin_en, rst_pin_pullup, cmp_to_cap;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit m_wen, m_wlong, m_sten, m_dbg, m_rpin, m_lock1;
    bit m_bclk, m_cmp, m_lock2, m_ill;

    always #10 clk = ~clk;

    sysopt_regs u0 (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(bit sel);
        if (sel) return {m_bclk, 6'b0, m_cmp};
        return {m_wen, m_wlong, m_sten, 3'b0, m_dbg, m_rpin};
    endfunction

    task automatic model_step();
        if (por_rst || sys_rst) begin
            m_wen = 1; m_wlong = 0; m_sten = 0; m_dbg = 1; m_lock1 = 0;
            m_bclk = 0; m_cmp = 0; m_lock2 = 0; m_ill = 0;
            if (por_rst) m_rpin = 0;
        end else begin
            m_ill = stop_try && !m_sten;
            if (bus_we && !bus_sel) begin
                if (!m_lock1) begin
                    m_wen = bus_wdata[7]; m_wlong = bus_wdata[6]; m_sten = bus_wdata[5];
                    m_rpin = m_rpin | bus_wdata[0]; m_lock1 = 1;
                end
                m_dbg = bus_wdata[1];
            end
            if (bus_we && bus_sel) begin
                if (!m_lock2) begin
                    m_bclk = bus_wdata[7]; m_lock2 = 1;
                end
                m_cmp = bus_wdata[0];
            end
        end
    endtask

    // one clock: model follows the edge, outputs compared 2 ns after it
    task automatic cyc();
        @(posedge clk);
        model_step();
        #2;
        chk("R7 read", bus_rdata, model_read(bus_sel));
        chk("R8 illegal", {7'b0, illegal_stop_req}, {7'b0, m_ill});
        chk("R9 wdog_en", {7'b0, wdog_en}, {7'b0, m_wen});
        chk("R9 wdog_long", {7'b0, wdog_long}, {7'b0, m_wlong});
        chk("R9 stop_ok", {7'b0, stop_ok}, {7'b0, m_sten});
        chk("R4 dbg_pin_en", {7'b0, dbg_pin_en}, {7'b0, m_dbg});
        chk("R2 rst_pin_en", {7'b0, rst_pin_en}, {7'b0, m_rpin});
        chk("R9 pullup", {7'b0, rst_pin_pullup}, {7'b0, m_rpin});
        chk("R5 wdog_busclk", {7'b0, wdog_busclk}, {7'b0, m_bclk});
        chk("R5 cmp_to_cap", {7'b0, cmp_to_cap}, {7'b0, m_cmp});
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        bus_sel = sel; bus_we = 1; bus_wdata = d;
        cyc();
        bus_we = 0; bus_wdata = 8'h00;
    endtask

    task automatic rd_expect(string req, bit sel, logic [7:0] exp);
        bus_sel = sel;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        por_rst = 1;
        cyc(); cyc();
        por_rst = 0;
        // R1 reset state
        rd_expect("R1 core default", 0, 8'h82);
        rd_expect("R1 route default", 1, 8'h00);
        cyc();

        // R8 STOP with stop disabled
        stop_try = 1; cyc(); stop_try = 0;
        chk("R8 pulse", {7'b0, illegal_stop_req}, 8'h01);
        cyc();
        chk("R8 one cycle", {7'b0, illegal_stop_req}, 8'h00);

        // R10 route write does not lock core; R5 route bits
        wr(1, 8'hFF);
        rd_expect("R6 route unimpl", 1, 8'h81);
        wr(0, 8'b0110_0011);
        rd_expect("R10 core first write after route write", 0, 8'h63);
        // R3 second write ignored on locked bits, R4 dbg follows, R6
        wr(0, 8'b1001_1100);
        rd_expect("R3 locked core", 0, 8'h61);
        wr(0, 8'h02);
        rd_expect("R4 dbg rewrite", 0, 8'h63);
        // R5 busclk locked, cmp free
        wr(1, 8'h00);
        rd_expect("R5 route second write", 1, 8'h80);

        // R8 STOP with stop enabled: no request
        stop_try = 1; cyc(); stop_try = 0;
        chk("R8 no pulse when enabled", {7'b0, illegal_stop_req}, 8'h00);
        cyc();

        // R2 general reset keeps reset-pin enable
        sys_rst = 1; stop_try = 1; cyc(); sys_rst = 0; stop_try = 0;
        chk("R2 rpin kept on sys_rst", {7'b0, rst_pin_en}, 8'h01);
        chk("R8 no pulse in reset", {7'b0, illegal_stop_req}, 8'h00);
        cyc();
        chk("R8 no pulse after reset stop", {7'b0, illegal_stop_req}, 8'h00);
        // R2 write cannot clear it
        wr(0, 8'h00);
        rd_expect("R2 rpin not cleared by write", 0, 8'h01);

        // R11 write during reset ignored and lock stays clear
        bus_sel = 1; bus_we = 1; bus_wdata = 8'h81; sys_rst = 1;
        cyc();
        sys_rst = 0; bus_we = 0;
        rd_expect("R11 write in reset", 1, 8'h00);
        wr(1, 8'h80);
        rd_expect("R11 lock clear after reset", 1, 8'h80);

        // R2 power-on reset clears it
        por_rst = 1; cyc(); por_rst = 0;
        rd_expect("R2 por clears rpin", 0, 8'h82);
        cyc();

        // varied patterns through the model
        for (int i = 0; i < 200; i++) begin
            bus_sel = i[0];
            bus_we = (i % 3) != 0;
            bus_wdata = 8'(i * 37 + 11);
            stop_try = (i % 5) == 2;
            sys_rst = (i % 41) == 40;
            por_rst = (i % 97) == 96;
            cyc();
        end
        sys_rst = 0; por_rst = 0; bus_we = 0; stop_try = 0;
        cyc();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule